// File: doc/BRIEF.md
# Multimode General-Purpose Timer

A single timer channel built around one shared counter, which runs in one of three modes. In waveform mode the counter measures out a programmable period, and the output is high for a programmable number of cycles at the start of each period. In measurement mode the channel timestamps the edges of an input signal. It reports how long the signal stayed high and how long a full high-plus-low cycle took. This suits measuring the bit time on a serial receive line so that a baud-rate divider can be set automatically. In event mode the counter advances once per rising edge of the input, and the channel raises an interrupt each time a programmed number of events has been seen.

The configuration inputs (enable, mode, period, width) are expected to come from a register bank. The external input is synchronised with a flop chain before any edge is detected. The interrupt output is a single-cycle pulse. In measurement mode the new width and period appear together with a one-cycle valid strobe.

Top module: `gpt_timer`

## Requirements
- R1: With cfg_enable high, mode code 0 (waveform), a nonzero period P and a width W below P, the counter starts from 0 in the first enabled cycle and runs 0..P-1 repeatedly. pwm_out is high exactly while the count is below W, so it is high for the first W of every P cycles; W of 0 gives a constantly low output.
- R2: In waveform mode irq is high for one cycle in the cycle after each period ends, so the first pulse comes P cycles after the first enabled cycle.
- R3: cfg_error is high when waveform mode has a period of 0 or a width not below the period, or when event mode (code 2) has a period of 0. While cfg_error is high, pwm_out is low and the counter is held at 0, even if input edges arrive.
- R4: When cfg_enable is low, or the mode code is 3, pwm_out is low at once and the counter reads 0 from the next cycle. A measurement in progress is abandoned, and overflow reads 0 from the next cycle. Out of reset all outputs are 0.
- R5: ext_in passes through a two-flop synchroniser, and edges are found after it. A rising edge driven onto ext_in changes count_value three clock edges later.
- R6: In event mode each rising edge of ext_in adds one to count_value. On the P-th edge the count returns to 0 and irq pulses for one cycle.
- R7: In measurement mode (code 1), once armed, cap_width is the number of cycles the input was high and cap_period is the number of cycles from one rising edge to the next. Both appear with cap_valid high for exactly one cycle. The completing rising edge also starts the next measurement, so back-to-back cycles are all reported.
- R8: In measurement mode irq pulses in the same cycle as cap_valid.
- R9: If the count would pass all-ones before a measurement completes, overflow is set and stays set while measurement mode stays enabled. The measurement is dropped, and the channel waits for a fresh rising edge before it measures again.
- R10: Measurement only arms on a rising edge. An input that is already high at enable, and the falling edge that follows, produce no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel run enable, level sensitive |
| cfg_mode | input | 2 | 0 waveform, 1 measurement, 2 event count, 3 off |
| cfg_period | input | CNT_W | Waveform period or event terminal count |
| cfg_width | input | CNT_W | Waveform high time in cycles |
| ext_in | input | 1 | Asynchronous input to measure or count |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | One-cycle interrupt pulse |
| cap_valid | output | 1 | One-cycle strobe for a new measurement |
| cap_width | output | CNT_W | Measured high time |
| cap_period | output | CNT_W | Measured rising-to-rising time |
| cfg_error | output | 1 | Illegal period/width setting for the current mode |
| overflow | output | 1 | Sticky counter overflow during measurement |
| count_value | output | CNT_W | Present counter value |

## Verification
On every cycle the assertions check several properties. The waveform output stays low when the channel is disabled or misconfigured, and is only high while the count is below the width. The waveform counter wraps to zero and raises the interrupt after its last count. The event count never moves by more than one step. Every measurement strobe lasts one cycle, reports a width below its period and coincides with an interrupt, and the overflow flag is sticky and clears when the channel is disabled. Only the directed scenarios can show the values themselves: the exact duty pattern and interrupt spacing, the three-edge synchroniser latency, the event wrap count, the measured widths and periods for chosen inputs, arming only on a rising edge, and recovery after an overflow.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [1:0] {
      MODE_PWM     = 2'd0,
      MODE_CAPTURE = 2'd1,
      MODE_EVCOUNT = 2'd2,
      MODE_OFF     = 2'd3
   } gpt_mode_e;

   typedef enum logic [1:0] {
      CMD_CLEAR = 2'd0,
      CMD_HOLD  = 2'd1,
      CMD_INC   = 2'd2,
      CMD_LOAD1 = 2'd3
   } gpt_cmd_e;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_HIGH = 2'd1,
      CAP_LOW  = 2'd2
   } gpt_cap_e;

endpackage

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);

   initial begin
      if (STAGES < 2) $fatal(1, "gpt_sync_edge: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_stage[g-1].q;
         end
      end
   end

   logic level;
   logic level_d;

   assign level = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign rise = level & ~level_d;
   assign fall = ~level & level_d;

endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core
   import gpt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gpt_cmd_e         cmd,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max
);

   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] ALL_ONE = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case (cmd)
            CMD_CLEAR: cnt <= '0;
            CMD_INC:   cnt <= cnt + ONE;
            CMD_LOAD1: cnt <= ONE;
            default:   cnt <= cnt;
         endcase
      end
   end

   assign at_max = (cnt == ALL_ONE);

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture
   import gpt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             rise,
   input  logic             fall,
   input  logic [CNT_W-1:0] cnt,
   input  logic             at_max,
   output gpt_cmd_e         cmd,
   output logic             done_now,
   output logic             cap_valid,
   output logic [CNT_W-1:0] cap_width,
   output logic [CNT_W-1:0] cap_period,
   output logic             overflow
);

   gpt_cap_e         state, state_n;
   logic [CNT_W-1:0] width_hold;
   logic             take_width;
   logic             ovf_set;

   always_comb begin
      state_n    = state;
      cmd        = CMD_CLEAR;
      done_now   = 1'b0;
      ovf_set    = 1'b0;
      take_width = 1'b0;
      if (!active) begin
         state_n = CAP_IDLE;
      end else begin
         case (state)
            CAP_IDLE: begin
               if (rise) begin
                  cmd     = CMD_LOAD1;
                  state_n = CAP_HIGH;
               end
            end
            CAP_HIGH: begin
               if (at_max) begin
                  ovf_set = 1'b1;
                  state_n = CAP_IDLE;
               end else begin
                  cmd = CMD_INC;
                  if (fall) begin
                     take_width = 1'b1;
                     state_n    = CAP_LOW;
                  end
               end
            end
            CAP_LOW: begin
               if (rise) begin
                  done_now = 1'b1;
                  cmd      = CMD_LOAD1;
                  state_n  = CAP_HIGH;
               end else if (at_max) begin
                  ovf_set = 1'b1;
                  state_n = CAP_IDLE;
               end else begin
                  cmd = CMD_INC;
               end
            end
            default: state_n = CAP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= CAP_IDLE;
         width_hold <= '0;
         cap_valid  <= 1'b0;
         cap_width  <= '0;
         cap_period <= '0;
         overflow   <= 1'b0;
      end else begin
         state     <= state_n;
         cap_valid <= done_now;
         if (take_width) width_hold <= cnt;
         if (done_now) begin
            cap_width  <= width_hold;
            cap_period <= cnt;
         end
         if (!active)      overflow <= 1'b0;
         else if (ovf_set) overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
   import gpt_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic [1:0]       cfg_mode,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_width,
   input  logic             ext_in,
   output logic             pwm_out,
   output logic             irq,
   output logic             cap_valid,
   output logic [CNT_W-1:0] cap_width,
   output logic [CNT_W-1:0] cap_period,
   output logic             cfg_error,
   output logic             overflow,
   output logic [CNT_W-1:0] count_value
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   initial begin
      if (CNT_W < 4 || CNT_W > 64) $fatal(1, "gpt_timer: CNT_W must be 4..64");
   end

   gpt_mode_e        mode;
   logic             rise, fall;
   logic             run_pwm, run_evc, cap_active;
   logic [CNT_W-1:0] period_m1;
   logic             at_last;
   logic             at_max;
   logic             wrap;
   logic             cap_done;
   gpt_cmd_e         cap_cmd;
   gpt_cmd_e         cmd;
   logic [CNT_W-1:0] cnt;

   assign mode = gpt_mode_e'(cfg_mode);

   always_comb begin
      cfg_error = 1'b0;
      if (mode == MODE_PWM)
         cfg_error = (cfg_period == '0) || (cfg_width >= cfg_period);
      else if (mode == MODE_EVCOUNT)
         cfg_error = (cfg_period == '0);
   end

   assign run_pwm    = cfg_enable && (mode == MODE_PWM)     && !cfg_error;
   assign run_evc    = cfg_enable && (mode == MODE_EVCOUNT) && !cfg_error;
   assign cap_active = cfg_enable && (mode == MODE_CAPTURE);
   assign period_m1  = cfg_period - ONE;
   assign at_last    = (cnt >= period_m1);

   gpt_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_in),
      .rise     (rise),
      .fall     (fall)
   );

   gpt_capture #(.CNT_W(CNT_W)) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (cap_active),
      .rise       (rise),
      .fall       (fall),
      .cnt        (cnt),
      .at_max     (at_max),
      .cmd        (cap_cmd),
      .done_now   (cap_done),
      .cap_valid  (cap_valid),
      .cap_width  (cap_width),
      .cap_period (cap_period),
      .overflow   (overflow)
   );

   always_comb begin
      cmd  = CMD_CLEAR;
      wrap = 1'b0;
      if (run_pwm) begin
         if (at_last) begin
            cmd  = CMD_CLEAR;
            wrap = 1'b1;
         end else begin
            cmd = CMD_INC;
         end
      end else if (run_evc) begin
         if (!rise) begin
            cmd = CMD_HOLD;
         end else if (at_last) begin
            cmd  = CMD_CLEAR;
            wrap = 1'b1;
         end else begin
            cmd = CMD_INC;
         end
      end else if (cap_active) begin
         cmd = cap_cmd;
      end
   end

   gpt_count_core #(.CNT_W(CNT_W)) i_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .cnt    (cnt),
      .at_max (at_max)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= wrap || cap_done;
   end

   assign pwm_out     = run_pwm && (cnt < cfg_width);
   assign count_value = cnt;

endmodule

// File: rtl/gpt_timer_checker.sv
module gpt_timer_checker
   import gpt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_enable,
   input logic [1:0]       cfg_mode,
   input logic [CNT_W-1:0] cfg_period,
   input logic [CNT_W-1:0] cfg_width,
   input logic             pwm_out,
   input logic             irq,
   input logic             cap_valid,
   input logic [CNT_W-1:0] cap_width,
   input logic [CNT_W-1:0] cap_period,
   input logic             cfg_error,
   input logic             overflow,
   input logic [CNT_W-1:0] count_value
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_pwm_below_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out |-> (count_value < cfg_width));

   p_pwm_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && cfg_mode == MODE_PWM && !cfg_error && count_value == cfg_period - ONE)
      |=> (count_value == '0));

   p_pwm_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && cfg_mode == MODE_PWM && !cfg_error && count_value == cfg_period - ONE)
      |=> irq);

   p_error_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> !pwm_out);

   p_error_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> (count_value == '0));

   p_disable_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |-> !pwm_out);

   p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!overflow && count_value == '0));

   p_event_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && cfg_mode == MODE_EVCOUNT && !cfg_error)
      |=> (count_value == $past(count_value) || count_value == $past(count_value) + ONE
           || count_value == '0));

   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> !cap_valid);

   p_width_below_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> (cap_width != '0 && cap_width < cap_period));

   p_capture_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> irq);

   p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && cfg_enable && cfg_mode == MODE_CAPTURE) |=> overflow);

endmodule

bind gpt_timer gpt_timer_checker #(.CNT_W(CNT_W)) i_gpt_timer_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_enable  (cfg_enable),
   .cfg_mode    (cfg_mode),
   .cfg_period  (cfg_period),
   .cfg_width   (cfg_width),
   .pwm_out     (pwm_out),
   .irq         (irq),
   .cap_valid   (cap_valid),
   .cap_width   (cap_width),
   .cap_period  (cap_period),
   .cfg_error   (cfg_error),
   .overflow    (overflow),
   .count_value (count_value)
);

// File: tb/test_gpt_timer.sv
module test_gpt_timer;

   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_enable = 1'b0;
   logic [1:0]       cfg_mode = 2'd0;
   logic [CNT_W-1:0] cfg_period = '0;
   logic [CNT_W-1:0] cfg_width = '0;
   logic             ext_in = 1'b0;
   logic             pwm_out, irq, cap_valid, cfg_error, overflow;
   logic [CNT_W-1:0] cap_width, cap_period, count_value;

   int checks = 0;
   int failures = 0;
   int cv_cnt = 0;
   int irq_cnt = 0;
   int first_w = 0, first_p = 0, last_w = 0, last_p = 0;

   always #5 clk = ~clk;

   gpt_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_gpt_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_enable  (cfg_enable),
      .cfg_mode    (cfg_mode),
      .cfg_period  (cfg_period),
      .cfg_width   (cfg_width),
      .ext_in      (ext_in),
      .pwm_out     (pwm_out),
      .irq         (irq),
      .cap_valid   (cap_valid),
      .cap_width   (cap_width),
      .cap_period  (cap_period),
      .cfg_error   (cfg_error),
      .overflow    (overflow),
      .count_value (count_value)
   );

   // monitor: samples strobes away from the clock edge
   always begin
      @(negedge clk);
      #2;
      if (cap_valid) begin
         if (cv_cnt == 0) begin
            first_w = int'(cap_width);
            first_p = int'(cap_period);
         end
         last_w = int'(cap_width);
         last_p = int'(cap_period);
         cv_cnt++;
      end
      if (irq) irq_cnt++;
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_mon();
      cv_cnt = 0;
      irq_cnt = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      #1;
      chk("R4", "reset pwm_out", pwm_out, 0);
      chk("R4", "reset irq", irq, 0);
      chk("R4", "reset cap_valid", cap_valid, 0);
      chk("R4", "reset overflow", overflow, 0);
      chk("R4", "reset count", count_value, 0);
   endtask

   task automatic t_pwm(input int p, input int w, input int n);
      int bad_out = 0;
      int bad_irq = 0;
      @(negedge clk);
      cfg_mode = 2'd0;
      cfg_period = CNT_W'(p);
      cfg_width = CNT_W'(w);
      cfg_enable = 1'b1;
      #1;
      for (int k = 0; k < n; k++) begin
         if (k > 0) begin
            @(negedge clk);
            #1;
         end
         if (pwm_out !== ((k % p) < w)) bad_out++;
         if (irq !== (k > 0 && (k % p) == 0)) bad_irq++;
      end
      chk("R1", $sformatf("pwm pattern P=%0d W=%0d mismatches", p, w), bad_out, 0);
      chk("R2", $sformatf("irq pattern P=%0d mismatches", p), bad_irq, 0);
      @(negedge clk);
      cfg_enable = 1'b0;
      #1;
      chk("R4", "pwm low right after disable", pwm_out, 0);
      @(negedge clk);
      #1;
      chk("R4", "count cleared after disable", count_value, 0);
   endtask

   task automatic t_error();
      int hi = 0;
      @(negedge clk);
      cfg_mode = 2'd0;
      cfg_period = CNT_W'(4);
      cfg_width = CNT_W'(4);
      cfg_enable = 1'b1;
      #1;
      chk("R3", "error width==period", cfg_error, 1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         #1;
         if (pwm_out) hi++;
      end
      chk("R3", "pwm high cycles under error", hi, 0);
      chk("R3", "count held under error", count_value, 0);
      cfg_period = '0;
      cfg_width = '0;
      #1;
      chk("R3", "error period 0", cfg_error, 1);
      cfg_mode = 2'd2;
      #1;
      chk("R3", "error event period 0", cfg_error, 1);
      for (int k = 0; k < 3; k++) begin
         ext_in = 1'b1;
         cyc(2);
         ext_in = 1'b0;
         cyc(2);
      end
      cyc(3);
      #1;
      chk("R3", "event count held under error", count_value, 0);
      cfg_enable = 1'b0;
      cyc(2);
   endtask

   task automatic t_mode_off();
      @(negedge clk);
      cfg_mode = 2'd3;
      cfg_period = CNT_W'(5);
      cfg_width = CNT_W'(2);
      cfg_enable = 1'b1;
      cyc(4);
      #1;
      chk("R4", "mode 3 pwm", pwm_out, 0);
      chk("R4", "mode 3 count", count_value, 0);
      cfg_enable = 1'b0;
      cyc(2);
   endtask

   task automatic t_event();
      @(negedge clk);
      cfg_mode = 2'd2;
      cfg_period = CNT_W'(5);
      ext_in = 1'b0;
      cfg_enable = 1'b1;
      cyc(3);
      clear_mon();
      ext_in = 1'b1;
      #1;
      chk("R5", "count before sync latency", count_value, 0);
      cyc(2);
      #1;
      chk("R5", "count after two edges", count_value, 0);
      cyc(1);
      #1;
      chk("R5", "count after three edges", count_value, 1);
      cyc(1);
      ext_in = 1'b0;
      cyc(2);
      for (int k = 0; k < 6; k++) begin
         ext_in = 1'b1;
         cyc(2);
         ext_in = 1'b0;
         cyc(2);
      end
      cyc(4);
      #1;
      chk("R6", "event count after 7 edges mod 5", count_value, 2);
      chk("R6", "event wrap irq pulses", irq_cnt, 1);
      cfg_enable = 1'b0;
      cyc(2);
   endtask

   task automatic t_capture(input int h1, input int l1, input int h2, input int l2);
      @(negedge clk);
      cfg_mode = 2'd1;
      ext_in = 1'b0;
      cfg_enable = 1'b1;
      cyc(4);
      clear_mon();
      ext_in = 1'b1;
      cyc(h1);
      ext_in = 1'b0;
      cyc(l1);
      ext_in = 1'b1;
      cyc(h2);
      ext_in = 1'b0;
      cyc(l2);
      ext_in = 1'b1;
      cyc(8);
      chk("R7", "capture count", cv_cnt, 2);
      chk("R7", "first width", first_w, h1);
      chk("R7", "first period", first_p, h1 + l1);
      chk("R7", "second width", last_w, h2);
      chk("R7", "second period", last_p, h2 + l2);
      chk("R8", "capture irq count", irq_cnt, 2);
      chk("R9", "no overflow on short pulses", overflow, 0);
      cfg_enable = 1'b0;
      ext_in = 1'b0;
      cyc(4);
   endtask

   task automatic t_arm();
      @(negedge clk);
      cfg_mode = 2'd1;
      ext_in = 1'b1;
      cyc(5);
      cfg_enable = 1'b1;
      clear_mon();
      cyc(3);
      ext_in = 1'b0;
      cyc(6);
      chk("R10", "no report before arming", cv_cnt, 0);
      ext_in = 1'b1;
      cyc(3);
      ext_in = 1'b0;
      cyc(4);
      ext_in = 1'b1;
      cyc(8);
      chk("R10", "one report after arming", cv_cnt, 1);
      chk("R10", "armed width", first_w, 3);
      chk("R10", "armed period", first_p, 7);
      cfg_enable = 1'b0;
      ext_in = 1'b0;
      cyc(4);
   endtask

   task automatic t_overflow();
      @(negedge clk);
      cfg_mode = 2'd1;
      ext_in = 1'b0;
      cfg_enable = 1'b1;
      cyc(3);
      clear_mon();
      ext_in = 1'b1;
      cyc(300);
      #1;
      chk("R9", "overflow after long high", overflow, 1);
      chk("R9", "no report on overflow", cv_cnt, 0);
      ext_in = 1'b0;
      cyc(3);
      ext_in = 1'b1;
      cyc(4);
      ext_in = 1'b0;
      cyc(5);
      ext_in = 1'b1;
      cyc(8);
      chk("R9", "report after re-arm", cv_cnt, 1);
      chk("R9", "width after re-arm", first_w, 4);
      chk("R9", "period after re-arm", first_p, 9);
      chk("R9", "overflow stays set", overflow, 1);
      cfg_enable = 1'b0;
      cyc(2);
      #1;
      chk("R4", "overflow cleared by disable", overflow, 0);
      ext_in = 1'b0;
      cyc(2);
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_pwm(5, 2, 23);
      t_pwm(4, 1, 17);
      t_pwm(6, 0, 13);
      t_error();
      t_mode_off();
      t_event();
      t_capture(8, 8, 8, 16);
      t_capture(1, 1, 3, 2);
      t_arm();
      t_overflow();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule